// File: doc/BRIEF.md
# Dual-Nibble LCD Pixel Deserializer

This block turns a single serial pixel stream into the two 4-bit data buses that feed a monochrome 640x480 panel, one bit per pixel. Each accepted input bit is steered alternately into an upper and a lower nibble shift register. Once eight bits have arrived, both nibbles are copied to the panel data buses and a one-cycle shift clock tells the panel to take them.

The block counts transfers within a row. After the last transfer of a 640-pixel row it raises a one-cycle line latch so that the panel holds the row. A frame pulse goes out together with the latch of the first row of every 480-row frame. A synchronous reset discards any partly filled nibbles and restarts both the transfer count and the row count.

Top module: `lcd_pixel_deser`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs go to zero and any partly gathered bits are discarded. After reset is released, the first shift clock needs eight fresh accepted bits.
- R2: Counting accepted bits k = 0..7 within a group, even k goes to the upper nibble and odd k goes to the lower nibble. Each new bit enters at bit 0 and older bits move up. So `upper_nib[3-j]` equals bit 2j and `lower_nib[3-j]` equals bit 2j+1. The nibble outputs hold their value in every cycle without a shift clock.
- R3: `shift_clk` is high for exactly one cycle. That cycle follows the clock edge that accepted the eighth bit of a group, and the new nibbles are on the buses in that same cycle.
- R4: A bit is accepted only at an edge where `in_stb` is high. `in_bit` has no effect while `in_stb` is low, and no shift clock appears before a group of eight bits is complete.
- R5: A row is 640/8 = 80 shift clocks. `line_latch` is a one-cycle pulse in the cycle right after the 80th shift clock of each row, and it is low at all other times.
- R6: `frame_pulse` is high only together with the line latch of row 0, which is the first row after reset and the first row of each frame.
- R7: The row count wraps after row 479, so the latch that follows the 480th row latch carries a frame pulse again.
- R8: A bit accepted in the cycle where the line latch is high is captured normally as the first bit of the next row, so a stream with no gaps runs across row boundaries without loss.
- R9: A reset in the middle of a row restarts the transfer count and the row count. The next 80 shift clocks then end in a line latch that carries a frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Serial pixel bit |
| in_stb | input | 1 | Accept `in_bit` at this edge |
| upper_nib | output | 4 | Upper panel data nibble |
| lower_nib | output | 4 | Lower panel data nibble |
| shift_clk | output | 1 | One-cycle pulse per 8-pixel transfer |
| line_latch | output | 1 | One-cycle pulse after each complete row |
| frame_pulse | output | 1 | Marks the row-0 latch of each frame |

## Verification
Two functions can fall in the same cycle. The line latch for a finished row can coincide with the acceptance of the first bit of the next row. In the same way, the frame marker always coincides with a row latch. The bench provokes the first case by streaming every byte value with no idle cycles, so strobes keep arriving through each latch cycle. It judges the result by predicting each group's nibbles bit by bit and requiring the row after the latch to decode exactly. It also predicts, from its own count of transfers and rows, the cycle in which the latch and the frame marker must appear.

// File: rtl/lcd_deser_pkg.sv
package lcd_deser_pkg;

  // Width of a counter that must hold values 0..n-1 (never below 1 bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of parallel transfers needed to carry one row of pixels.
  function automatic int unsigned xfers_per_row(input int unsigned row_px,
                                                input int unsigned nib_w);
    return row_px / (2 * nib_w);
  endfunction

endpackage

// File: rtl/lcd_nib_capture.sv
module lcd_nib_capture
  import lcd_deser_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_bit,
  input  logic             in_stb,
  output logic             grp_done,
  output logic [NIB_W-1:0] grp_upper,
  output logic [NIB_W-1:0] grp_lower
);
  localparam int unsigned GRP_BITS = 2 * NIB_W;
  localparam int unsigned BW       = cnt_width(GRP_BITS);

  logic [BW-1:0]    bit_idx;
  logic [NIB_W-1:0] up_sr;
  logic [NIB_W-1:0] lo_sr;
  logic             to_lower;
  logic             last_bit;

  // Even positions feed the upper register, odd positions the lower one.
  assign to_lower = bit_idx[0];
  assign last_bit = (bit_idx == BW'(GRP_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      up_sr   <= '0;
      lo_sr   <= '0;
    end else if (in_stb) begin
      if (to_lower) lo_sr <= {lo_sr[NIB_W-2:0], in_bit};
      else          up_sr <= {up_sr[NIB_W-2:0], in_bit};
      bit_idx <= last_bit ? '0 : bit_idx + BW'(1);
    end
  end

  // The closing bit always lands in the lower register; bypass it here.
  assign grp_done  = in_stb && last_bit;
  assign grp_upper = up_sr;
  assign grp_lower = {lo_sr[NIB_W-2:0], in_bit};

endmodule

// File: rtl/lcd_xfer_count.sv
module lcd_xfer_count
  import lcd_deser_pkg::*;
#(
  parameter int unsigned XFERS = 80,
  localparam int unsigned XW   = cnt_width(XFERS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grp_done,
  output logic          row_end,
  output logic [XW-1:0] xfer_idx
);
  logic at_last;

  assign at_last = (xfer_idx == XW'(XFERS - 1));
  assign row_end = grp_done && at_last;

  always_ff @(posedge clk) begin
    if (rst)           xfer_idx <= '0;
    else if (grp_done) xfer_idx <= at_last ? '0 : xfer_idx + XW'(1);
  end

endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
  import lcd_deser_pkg::*;
#(
  parameter int unsigned ROWS = 480,
  localparam int unsigned RW  = cnt_width(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_end,
  output logic          line_latch,
  output logic          frame_pulse,
  output logic [RW-1:0] row_idx
);
  logic latch_pend;

  // latch_pend lines up with the last shift clock of the row; the latch
  // and the row advance follow one cycle later.
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_pend  <= 1'b0;
      line_latch  <= 1'b0;
      frame_pulse <= 1'b0;
      row_idx     <= '0;
    end else begin
      latch_pend  <= row_end;
      line_latch  <= latch_pend;
      frame_pulse <= latch_pend && (row_idx == '0);
      if (latch_pend)
        row_idx <= (row_idx == RW'(ROWS - 1)) ? '0 : row_idx + RW'(1);
    end
  end

endmodule

// File: rtl/lcd_pixel_deser.sv
module lcd_pixel_deser
  import lcd_deser_pkg::*;
#(
  parameter int unsigned NIB_W      = 4,
  parameter int unsigned ROW_PIXELS = 640,
  parameter int unsigned FRAME_ROWS = 480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_bit,
  input  logic             in_stb,
  output logic [NIB_W-1:0] upper_nib,
  output logic [NIB_W-1:0] lower_nib,
  output logic             shift_clk,
  output logic             line_latch,
  output logic             frame_pulse
);
  localparam int unsigned XFERS = xfers_per_row(ROW_PIXELS, NIB_W);
  localparam int unsigned XW    = cnt_width(XFERS);
  localparam int unsigned RW    = cnt_width(FRAME_ROWS);

  // Internal events, named for the checker.
  logic             grp_done;
  logic [NIB_W-1:0] grp_upper;
  logic [NIB_W-1:0] grp_lower;
  logic             row_end;
  logic [XW-1:0]    xfer_idx;
  logic [RW-1:0]    row_idx;

  lcd_nib_capture #(.NIB_W(NIB_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .in_bit    (in_bit),
    .in_stb    (in_stb),
    .grp_done  (grp_done),
    .grp_upper (grp_upper),
    .grp_lower (grp_lower)
  );

  lcd_xfer_count #(.XFERS(XFERS)) u_xfer (
    .clk      (clk),
    .rst      (rst),
    .grp_done (grp_done),
    .row_end  (row_end),
    .xfer_idx (xfer_idx)
  );

  lcd_row_seq #(.ROWS(FRAME_ROWS)) u_row (
    .clk         (clk),
    .rst         (rst),
    .row_end     (row_end),
    .line_latch  (line_latch),
    .frame_pulse (frame_pulse),
    .row_idx     (row_idx)
  );

  // Output stage: present a finished group with a one-cycle shift clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      upper_nib <= '0;
      lower_nib <= '0;
      shift_clk <= 1'b0;
    end else begin
      shift_clk <= grp_done;
      if (grp_done) begin
        upper_nib <= grp_upper;
        lower_nib <= grp_lower;
      end
    end
  end

endmodule

// File: rtl/lcd_deser_chk.sv
module lcd_deser_chk #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned XFERS = 80,
  parameter int unsigned ROWS  = 480,
  parameter int unsigned XW    = 7,
  parameter int unsigned RW    = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             in_stb,
  input logic             shift_clk,
  input logic             line_latch,
  input logic             frame_pulse,
  input logic [NIB_W-1:0] upper_nib,
  input logic [NIB_W-1:0] lower_nib,
  input logic [XW-1:0]    xfer_idx,
  input logic [RW-1:0]    row_idx
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!shift_clk && !line_latch && !frame_pulse));

  // R2
  nib_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_clk |-> ($stable(upper_nib) && $stable(lower_nib)));

  // R3
  shift_single_chk: assert property (@(posedge clk) disable iff (rst)
    shift_clk |=> !shift_clk);

  // R4
  shift_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    shift_clk |-> $past(in_stb));

  // R5
  latch_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    line_latch |-> ($past(shift_clk) && $past(xfer_idx) == '0));

  // R6
  frame_with_latch_chk: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> line_latch);

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    line_latch |-> (int'(row_idx) == (int'($past(row_idx)) + 1) % int'(ROWS)));

  // R9
  xfer_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(xfer_idx) < int'(XFERS));

endmodule

bind lcd_pixel_deser lcd_deser_chk #(
  .NIB_W(NIB_W), .XFERS(XFERS), .ROWS(FRAME_ROWS), .XW(XW), .RW(RW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_stb      (in_stb),
  .shift_clk   (shift_clk),
  .line_latch  (line_latch),
  .frame_pulse (frame_pulse),
  .upper_nib   (upper_nib),
  .lower_nib   (lower_nib),
  .xfer_idx    (xfer_idx),
  .row_idx     (row_idx)
);

// File: tb/tb_lcd_pixel_deser.sv
module tb_lcd_pixel_deser;
  localparam int CLK_PERIOD = 10;
  localparam int NIB        = 4;
  localparam int RPX        = 32;
  localparam int ROWS       = 4;
  localparam int XF         = RPX / (2 * NIB);
  localparam int WATCHDOG   = 50000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_bit = 1'b0;
  logic           in_stb = 1'b0;
  logic [NIB-1:0] upper_nib, lower_nib;
  logic           shift_clk, line_latch, frame_pulse;

  lcd_pixel_deser #(.NIB_W(NIB), .ROW_PIXELS(RPX), .FRAME_ROWS(ROWS)) dut (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_stb(in_stb),
    .upper_nib(upper_nib), .lower_nib(lower_nib), .shift_clk(shift_clk),
    .line_latch(line_latch), .frame_pulse(frame_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_checks = 0, n_errors = 0, cycles = 0;
  logic [7:0] exp_q[$];
  int   sent = 0, seen = 0, xf_seen = 0, row_model = 0;
  bit   latch_due = 1'b0;
  logic [7:0] last_byte = 8'h00;
  int   obs_latch = 0, obs_frame = 0, exp_frame_cnt = 0, overlap = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench's own mapping: upper bit (3-j) = serial bit 2j, lower = 2j+1.
  function automatic logic [NIB-1:0] up_of(input logic [7:0] b);
    logic [NIB-1:0] r;
    for (int j = 0; j < NIB; j++) r[NIB-1-j] = b[2*j];
    return r;
  endfunction
  function automatic logic [NIB-1:0] lo_of(input logic [7:0] b);
    logic [NIB-1:0] r;
    for (int j = 0; j < NIB; j++) r[NIB-1-j] = b[2*j+1];
    return r;
  endfunction

  // Monitor: samples one time unit after each rising edge.
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst && !done) begin
      bit exp_fr;
      exp_fr = latch_due && (row_model == 0);
      check(line_latch === latch_due, "R5", "line_latch", line_latch, latch_due);
      check(frame_pulse === exp_fr, "R6", "frame_pulse", frame_pulse, exp_fr);
      if (line_latch) obs_latch++;
      if (frame_pulse) obs_frame++;
      if (exp_fr) exp_frame_cnt++;
      if (line_latch && in_stb) overlap++;
      if (latch_due) row_model = (row_model + 1) % ROWS;
      latch_due = 1'b0;
      if (sent > seen) begin
        check(shift_clk === 1'b1, "R3", "shift_clk after 8th bit", shift_clk, 1);
        last_byte = exp_q.pop_front();
        seen++;
        xf_seen++;
        if (xf_seen == XF) begin latch_due = 1'b1; xf_seen = 0; end
      end else begin
        check(shift_clk === 1'b0, "R4", "shift_clk idle", shift_clk, 0);
      end
      check(upper_nib === up_of(last_byte), "R2", "upper_nib", upper_nib, up_of(last_byte));
      check(lower_nib === lo_of(last_byte), "R2", "lower_nib", lower_nib, lo_of(last_byte));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_stb = 1'b0;
      in_bit = ~in_bit;  // garbage while the strobe is low (R4)
    end
  endtask

  task automatic send_bit(input logic v, input bit closes, input logic [7:0] b);
    @(negedge clk);
    in_stb = 1'b1;
    in_bit = v;
    if (closes) begin
      exp_q.push_back(b);
      sent++;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    for (int k = 0; k < 8; k++) begin
      if (gap > 0 && k == 3) idle(gap);
      send_bit(b[k], k == 7, b);
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    in_stb = 1'b0;
    repeat (n) @(negedge clk);
    exp_q.delete();
    sent = 0; seen = 0; xf_seen = 0; row_model = 0;
    latch_due = 1'b0; last_byte = 8'h00;
    rst = 1'b0;
  endtask

  initial begin
    int l0, f0;
    do_reset(3);
    // R1: reset state
    check(upper_nib === '0, "R1", "upper_nib after reset", upper_nib, 0);
    check(lower_nib === '0, "R1", "lower_nib after reset", lower_nib, 0);
    check(shift_clk === 1'b0, "R1", "shift_clk after reset", shift_clk, 0);
    check({line_latch, frame_pulse} === 2'b00, "R1", "latch/frame after reset",
          {line_latch, frame_pulse}, 0);

    // Sweep every byte back to back: latches meet live strobes (R8, R7 wrap).
    for (int b = 0; b < 256; b++) send_byte(8'(b), 0);
    idle(4);
    check(overlap > 0, "R8", "strobes accepted in latch cycles", overlap, 1);
    check(seen == 256, "R8", "groups delivered", seen, 256);

    // Sweep again with idle gaps and garbage data inside groups (R4).
    for (int b = 0; b < 256; b++) send_byte(8'(255 - b), b % 3);
    idle(4);
    check(obs_frame == exp_frame_cnt, "R7", "frame pulses over wraps", obs_frame, exp_frame_cnt);
    check(obs_latch == 512 / XF, "R5", "row latch count", obs_latch, 512 / XF);

    // Reset in the middle of a group discards partial bits (R1).
    send_bit(1'b1, 0, 8'h00);
    send_bit(1'b0, 0, 8'h00);
    send_bit(1'b1, 0, 8'h00);
    do_reset(2);
    send_byte(8'hA5, 0);
    idle(3);
    check(seen == 1, "R1", "one group after mid-group reset", seen, 1);

    // Reset in the middle of a row restarts the row/transfer counts (R9).
    send_byte(8'h3C, 0);
    do_reset(2);
    l0 = obs_latch; f0 = obs_frame;
    for (int i = 0; i < XF; i++) send_byte(8'(8'h11 * i), 0);
    idle(4);
    check(obs_latch - l0 == 1, "R9", "latch after full row post reset", obs_latch - l0, 1);
    check(obs_frame - f0 == 1, "R9", "frame on first row post reset", obs_frame - f0, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule